// File: doc/BRIEF.md
# Three-Slot Bundle Dispersal Unit

This block sits between instruction fetch and the functional units of a wide in-order core. Each cycle the fetch side offers up to two 128-bit bundles. A bundle carries a 5-bit template code in bits [4:0] and three 41-bit slots: slot 0 in [45:5], slot 1 in [86:46] and slot 2 in [127:87]. The template code, not the opcodes, gives the unit kind of every slot and the positions of the group stops. The block walks the slots in program order and places each one on the first free port of a matching kind. Group stops, port counts and an all-or-nothing rule for the second bundle limit how far the walk goes.

The port image is registered, so the chosen operations show on the port outputs one clock after the offer. The handshake back to fetch is combinational in the same cycle as the offer. It gives the number of whole bundles consumed and the slot at which the first remaining bundle must be offered again. A memory port, an integer/shift port, a floating-point port and a branch port family are provided. An integer-ALU slot may go to an integer port or a memory port. A long two-slot operation travels as one 82-bit word on an integer port.

Top module: `bundle_disperse`

## Requirements
- R1: Template bits [4:1] select the slot kinds for slots 0,1,2. The codes are: 0 MII, 1 MII with a stop after slot 1, 2 MLX, 3 MMI, 4 MMI with a stop after slot 0, 5 MFI, 6 MMF, 7 MIB, 8 MBB, 9 BBB, 10 MMB, 11 MFB, 12 AAB. Template bit 0 adds a stop after slot 2. Each slot goes to the lowest-numbered free port of its kind (M: memory, I: integer, F: floating point, B: branch). Memory and integer slots are counted in program order across both bundles.
- R2: Template codes 0x1A to 0x1F are illegal. An illegal code in the first bundle raises `bad_tmpl`, issues nothing in that cycle (no port valid on the following cycle), and reports `used_cnt`=1 and `resume_slot`=0. An illegal code in the second bundle keeps that bundle from issuing and does not raise `bad_tmpl`.
- R3: Issue of the first bundle starts at slot `b0_start`. Slots before it are not issued. A port shows the chosen slot on the clock edge after the offer. A 41-bit slot on an integer port sits in the low 41 bits and the upper bits are zero.
- R4: An A slot takes a free integer port if there is one, and otherwise a free memory port.
- R5: In an MLX bundle, slots 1 and 2 issue together as one operation on a single integer port, with slot 2 in the upper 41 bits and slot 1 in the lower 41 bits.
- R6: When the first bundle is valid and legal but is not fully consumed, `resume_slot` is greater than `b0_start`, so each offer makes progress.
- R7: A stop after slot k of the first bundle keeps later slots from issuing in that cycle. If k<2 the result is `used_cnt`=0 and `resume_slot`=k+1. If k=2 the result is `used_cnt`=1 and `resume_slot`=0, and the second bundle does not issue.
- R8: The second bundle issues in the same cycle only if all of the following hold: the first bundle issued completely with no stop after its slot 2, the second bundle is valid and legal with no stop after slot 0 or slot 1, and ports are free for all of its slots. When it issues, all of its slots issue and `used_cnt`=2. Otherwise none of its slots issue. Ports default to 2 M, 2 I, 2 F and 3 B.
- R9: With `b0_valid` low, nothing issues, `used_cnt`=0, `bad_tmpl` is low, and `resume_slot` equals `b0_start`.
- R10: During and right after reset, every port valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| b0_valid | input | 1 | First (older) bundle offered |
| b0_data | input | 128 | First bundle: template and three slots |
| b0_start | input | 2 | First slot of the first bundle still to issue |
| b1_valid | input | 1 | Second bundle offered |
| b1_data | input | 128 | Second bundle |
| used_cnt | output | 2 | Whole bundles consumed this cycle |
| resume_slot | output | 2 | Slot at which the oldest remaining bundle restarts |
| bad_tmpl | output | 1 | First bundle carries an illegal template |
| m_vld | output | NM | Memory port valids |
| m_op | output | NM*41 | Memory port operations |
| i_vld | output | NI | Integer port valids |
| i_op | output | NI*82 | Integer port operations (long form uses all 82 bits) |
| f_vld | output | NF | Floating-point port valids |
| f_op | output | NF*41 | Floating-point port operations |
| b_vld | output | NB | Branch port valids |
| b_op | output | NB*41 | Branch port operations |

## Verification
The hardest case to reach is the memory fallback of an integer-ALU slot. The port budget is only shared inside a pair, so the first bundle must use exactly one integer port and leave one memory port free before the A slots of the second bundle arrive. The stimulus pairs an MFI bundle with an AAB bundle, which forces the second A onto the memory port. Stop-driven restarts are reached by offering the same bundle twice, with the start slot taken from the previous `resume_slot`. Rejection of the second bundle is reached separately through port shortage, an interior stop, an end stop in the first bundle and an illegal code.

// File: rtl/disp_pkg.sv
package disp_pkg;
   localparam int TMPL_W = 5;

   typedef enum logic [2:0] {
      U_M    = 3'd0,
      U_I    = 3'd1,
      U_A    = 3'd2,
      U_F    = 3'd3,
      U_B    = 3'd4,
      U_L    = 3'd5,
      U_X    = 3'd6,
      U_NONE = 3'd7
   } unit_e;

   typedef struct packed {
      logic             legal;
      logic [2:0][2:0]  kind;   // kind[k] holds a unit_e for slot k
      logic [2:0]       stop;   // stop[k]: group ends after slot k
   } tmpl_t;

   function automatic tmpl_t decode_tmpl(input logic [TMPL_W-1:0] code);
      tmpl_t t;
      t.legal = 1'b1;
      t.stop  = {code[0], 2'b00};
      t.kind  = {U_NONE, U_NONE, U_NONE};
      case (code[4:1])
         4'd0:  t.kind = {U_I, U_I, U_M};
         4'd1:  begin t.kind = {U_I, U_I, U_M}; t.stop[1] = 1'b1; end
         4'd2:  t.kind = {U_X, U_L, U_M};
         4'd3:  t.kind = {U_I, U_M, U_M};
         4'd4:  begin t.kind = {U_I, U_M, U_M}; t.stop[0] = 1'b1; end
         4'd5:  t.kind = {U_I, U_F, U_M};
         4'd6:  t.kind = {U_F, U_M, U_M};
         4'd7:  t.kind = {U_B, U_I, U_M};
         4'd8:  t.kind = {U_B, U_B, U_M};
         4'd9:  t.kind = {U_B, U_B, U_B};
         4'd10: t.kind = {U_B, U_M, U_M};
         4'd11: t.kind = {U_B, U_F, U_M};
         4'd12: t.kind = {U_B, U_A, U_A};
         default: begin t.legal = 1'b0; t.stop = 3'b000; end
      endcase
      return t;
   endfunction
endpackage

// File: rtl/disp_tmpl_dec.sv
module disp_tmpl_dec
   import disp_pkg::*;
(
   input  logic [TMPL_W-1:0] code,
   output tmpl_t             tmpl
);
   assign tmpl = decode_tmpl(code);
endmodule

// File: rtl/disp_alloc.sv
module disp_alloc
   import disp_pkg::*;
#(
   parameter int NM = 2,
   parameter int NI = 2,
   parameter int NF = 2,
   parameter int NB = 3,
   parameter int SW = 41,
   parameter bit A_PREFER_I = 1'b1,
   localparam int BW = TMPL_W + 3*SW
)(
   input  logic [BW-1:0]           bnd0,
   input  logic [BW-1:0]           bnd1,
   input  tmpl_t                   t0,
   input  tmpl_t                   t1,
   input  logic                    v0,
   input  logic                    v1,
   input  logic [1:0]              start,
   output logic [1:0]              used,
   output logic [1:0]              resume,
   output logic                    bad,
   output logic [NM-1:0]           mv,
   output logic [NM-1:0][SW-1:0]   mo,
   output logic [NI-1:0]           iv,
   output logic [NI-1:0][2*SW-1:0] io,
   output logic [NF-1:0]           fv,
   output logic [NF-1:0][SW-1:0]   fo,
   output logic [NB-1:0]           bv,
   output logic [NB-1:0][SW-1:0]   bo
);
   typedef struct packed {
      logic [NM-1:0]           mv;
      logic [NM-1:0][SW-1:0]   mo;
      logic [NI-1:0]           iv;
      logic [NI-1:0][2*SW-1:0] io;
      logic [NF-1:0]           fv;
      logic [NF-1:0][SW-1:0]   fo;
      logic [NB-1:0]           bv;
      logic [NB-1:0][SW-1:0]   bo;
   } pst_t;

   function automatic pst_t put_m(input pst_t st, input logic [SW-1:0] op, output logic got);
      pst_t r = st;
      got = 1'b0;
      for (int p = 0; p < NM; p++)
         if (!got && !r.mv[p]) begin r.mv[p] = 1'b1; r.mo[p] = op; got = 1'b1; end
      return r;
   endfunction

   function automatic pst_t put_i(input pst_t st, input logic [2*SW-1:0] op, output logic got);
      pst_t r = st;
      got = 1'b0;
      for (int p = 0; p < NI; p++)
         if (!got && !r.iv[p]) begin r.iv[p] = 1'b1; r.io[p] = op; got = 1'b1; end
      return r;
   endfunction

   function automatic pst_t place(input pst_t st, input unit_e k,
                                  input logic [2*SW-1:0] op, output logic ok);
      pst_t r = st;
      logic got = 1'b0;
      logic [2*SW-1:0] narrow = {{SW{1'b0}}, op[SW-1:0]};
      case (k)
         U_M: r = put_m(r, op[SW-1:0], got);
         U_I: r = put_i(r, narrow, got);
         U_L: r = put_i(r, op, got);
         U_A: begin
            if (A_PREFER_I) begin
               r = put_i(r, narrow, got);
               if (!got) r = put_m(r, op[SW-1:0], got);
            end else begin
               r = put_m(r, op[SW-1:0], got);
               if (!got) r = put_i(r, narrow, got);
            end
         end
         U_F: for (int p = 0; p < NF; p++)
            if (!got && !r.fv[p]) begin r.fv[p] = 1'b1; r.fo[p] = op[SW-1:0]; got = 1'b1; end
         U_B: for (int p = 0; p < NB; p++)
            if (!got && !r.bv[p]) begin r.bv[p] = 1'b1; r.bo[p] = op[SW-1:0]; got = 1'b1; end
         U_X: got = 1'b1;    // travels with the preceding long slot
         default: got = 1'b0;
      endcase
      ok = got;
      return r;
   endfunction

   logic [BW+SW-1:0] ext0, ext1;
   assign ext0 = {{SW{1'b0}}, bnd0};
   assign ext1 = {{SW{1'b0}}, bnd1};

   always_comb begin
      pst_t s, keep;
      logic ok, halt, ok1;
      logic [2:0] nxt;
      s      = '0;
      keep   = '0;
      ok     = 1'b0;
      halt   = 1'b0;
      ok1    = 1'b0;
      nxt    = 3'd3;
      bad    = 1'b0;
      used   = 2'd0;
      resume = start;
      if (v0 && !t0.legal) begin
         bad    = 1'b1;
         used   = 2'd1;
         resume = 2'd0;
      end else if (v0) begin
         for (int k = 0; k < 3; k++) begin
            if (!halt && start <= 2'(k)) begin
               s = place(s, unit_e'(t0.kind[k]),
                         {ext0[TMPL_W+(k+1)*SW +: SW], ext0[TMPL_W+k*SW +: SW]}, ok);
               if (!ok) begin
                  halt = 1'b1;
                  nxt  = 3'(k);
               end else if (t0.stop[k]) begin
                  halt = 1'b1;
                  nxt  = 3'(k + 1);
               end
            end
         end
         if (nxt == 3'd3) begin
            used   = 2'd1;
            resume = 2'd0;
         end else begin
            resume = nxt[1:0];
         end
         if (!halt && v1 && t1.legal && t1.stop[1:0] == 2'b00) begin
            keep = s;
            ok1  = 1'b1;
            for (int k = 0; k < 3; k++) begin
               s = place(s, unit_e'(t1.kind[k]),
                         {ext1[TMPL_W+(k+1)*SW +: SW], ext1[TMPL_W+k*SW +: SW]}, ok);
               ok1 = ok1 & ok;
            end
            if (ok1) used = 2'd2;
            else     s    = keep;
         end
      end
      mv = s.mv; mo = s.mo;
      iv = s.iv; io = s.io;
      fv = s.fv; fo = s.fo;
      bv = s.bv; bo = s.bo;
   end
endmodule

// File: rtl/bundle_disperse.sv
module bundle_disperse
   import disp_pkg::*;
#(
   parameter int NM = 2,
   parameter int NI = 2,
   parameter int NF = 2,
   parameter int NB = 3,
   parameter int SW = 41,
   parameter bit A_PREFER_I = 1'b1,
   localparam int BW = TMPL_W + 3*SW
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    b0_valid,
   input  logic [BW-1:0]           b0_data,
   input  logic [1:0]              b0_start,
   input  logic                    b1_valid,
   input  logic [BW-1:0]           b1_data,
   output logic [1:0]              used_cnt,
   output logic [1:0]              resume_slot,
   output logic                    bad_tmpl,
   output logic [NM-1:0]           m_vld,
   output logic [NM-1:0][SW-1:0]   m_op,
   output logic [NI-1:0]           i_vld,
   output logic [NI-1:0][2*SW-1:0] i_op,
   output logic [NF-1:0]           f_vld,
   output logic [NF-1:0][SW-1:0]   f_op,
   output logic [NB-1:0]           b_vld,
   output logic [NB-1:0][SW-1:0]   b_op
);
   if (NM < 1 || NI < 1 || NF < 1 || NB < 1) begin : g_bad_ports
      $error("bundle_disperse: every port family needs at least one port");
   end
   if (SW < 1) begin : g_bad_width
      $error("bundle_disperse: slot width must be positive");
   end

   logic [1:0][BW-1:0] bnd;
   tmpl_t              tdec [2];
   assign bnd = {b1_data, b0_data};

   for (genvar g = 0; g < 2; g++) begin : g_dec
      disp_tmpl_dec u_dec (.code(bnd[g][TMPL_W-1:0]), .tmpl(tdec[g]));
   end

   logic [NM-1:0]           n_mv;
   logic [NM-1:0][SW-1:0]   n_mo;
   logic [NI-1:0]           n_iv;
   logic [NI-1:0][2*SW-1:0] n_io;
   logic [NF-1:0]           n_fv;
   logic [NF-1:0][SW-1:0]   n_fo;
   logic [NB-1:0]           n_bv;
   logic [NB-1:0][SW-1:0]   n_bo;

   disp_alloc #(.NM(NM), .NI(NI), .NF(NF), .NB(NB), .SW(SW), .A_PREFER_I(A_PREFER_I)) u_alloc (
      .bnd0(bnd[0]), .bnd1(bnd[1]), .t0(tdec[0]), .t1(tdec[1]),
      .v0(b0_valid), .v1(b1_valid), .start(b0_start),
      .used(used_cnt), .resume(resume_slot), .bad(bad_tmpl),
      .mv(n_mv), .mo(n_mo), .iv(n_iv), .io(n_io),
      .fv(n_fv), .fo(n_fo), .bv(n_bv), .bo(n_bo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_vld <= '0; m_op <= '0;
         i_vld <= '0; i_op <= '0;
         f_vld <= '0; f_op <= '0;
         b_vld <= '0; b_op <= '0;
      end else begin
         m_vld <= n_mv; m_op <= n_mo;
         i_vld <= n_iv; i_op <= n_io;
         f_vld <= n_fv; f_op <= n_fo;
         b_vld <= n_bv; b_op <= n_bo;
      end
   end
endmodule

// File: rtl/bundle_disperse_chk.sv
module bundle_disperse_chk #(
   parameter int NM = 2,
   parameter int NI = 2,
   parameter int NF = 2,
   parameter int NB = 3
)(
   input logic          clk,
   input logic          rst_n,
   input logic          b0_valid,
   input logic [1:0]    b0_start,
   input logic          b1_valid,
   input logic [1:0]    used_cnt,
   input logic [1:0]    resume_slot,
   input logic          bad_tmpl,
   input logic [NM-1:0] m_vld,
   input logic [NI-1:0] i_vld,
   input logic [NF-1:0] f_vld,
   input logic [NB-1:0] b_vld
);
   logic quiet;
   assign quiet = (m_vld == '0) && (i_vld == '0) && (f_vld == '0) && (b_vld == '0);

   assert_bad_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (b0_valid && bad_tmpl) |=> quiet);
   assert_bad_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (b0_valid && bad_tmpl) |-> (used_cnt == 2'd1 && resume_slot == 2'd0));
   assert_progress_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (b0_valid && !bad_tmpl && used_cnt == 2'd0) |-> (resume_slot > b0_start));
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (b0_valid && used_cnt != 2'd0) |-> (resume_slot == 2'd0));
   assert_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (used_cnt == 2'd2) |-> (b0_valid && b1_valid && !bad_tmpl));
   assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      used_cnt != 2'd3);
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !b0_valid |-> (used_cnt == 2'd0 && !bad_tmpl && resume_slot == b0_start));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !b0_valid |=> quiet);
   always_comb begin
      if (!rst_n) assert_reset_R10: assert (quiet);
   end
endmodule

bind bundle_disperse bundle_disperse_chk #(.NM(NM), .NI(NI), .NF(NF), .NB(NB)) u_chk (
   .clk(clk), .rst_n(rst_n), .b0_valid(b0_valid), .b0_start(b0_start),
   .b1_valid(b1_valid), .used_cnt(used_cnt), .resume_slot(resume_slot),
   .bad_tmpl(bad_tmpl), .m_vld(m_vld), .i_vld(i_vld), .f_vld(f_vld), .b_vld(b_vld)
);

// File: tb/sim_bundle_disperse.sv
module sim_bundle_disperse;
   localparam int PER = 10;

   typedef struct packed {
      logic [1:0]        mv;
      logic [1:0][40:0]  mo;
      logic [1:0]        iv;
      logic [1:0][81:0]  io;
      logic [1:0]        fv;
      logic [1:0][40:0]  fo;
      logic [2:0]        bv;
      logic [2:0][40:0]  bo;
   } img_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic b0_valid = 1'b0, b1_valid = 1'b0;
   logic [127:0] b0_data = '0, b1_data = '0;
   logic [1:0] b0_start = '0;
   logic [1:0] used_cnt, resume_slot;
   logic bad_tmpl;
   logic [1:0] m_vld, i_vld, f_vld;
   logic [2:0] b_vld;
   logic [1:0][40:0] m_op, f_op;
   logic [1:0][81:0] i_op;
   logic [2:0][40:0] b_op;

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   img_t  sbq [$];
   string tagq[$];

   always #(PER/2) clk = ~clk;

   bundle_disperse u0 (
      .clk(clk), .rst_n(rst_n), .b0_valid(b0_valid), .b0_data(b0_data), .b0_start(b0_start),
      .b1_valid(b1_valid), .b1_data(b1_data), .used_cnt(used_cnt), .resume_slot(resume_slot),
      .bad_tmpl(bad_tmpl), .m_vld(m_vld), .m_op(m_op), .i_vld(i_vld), .i_op(i_op),
      .f_vld(f_vld), .f_op(f_op), .b_vld(b_vld), .b_op(b_op)
   );

   function automatic logic [40:0] sv(input int id, input int k);
      return 41'(64'h155_0000_0000 + id*8 + k);
   endfunction

   function automatic logic [127:0] mk(input logic [4:0] code, input int id);
      return {sv(id, 2), sv(id, 1), sv(id, 0), code};
   endfunction

   function automatic img_t got_img();
      img_t g;
      g.mv = m_vld; g.mo = m_op; g.iv = i_vld; g.io = i_op;
      g.fv = f_vld; g.fo = f_op; g.bv = b_vld; g.bo = b_op;
      return g;
   endfunction

   task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: one offer per cycle, handshake checked at once, port image queued
   task automatic offer(input logic v0, input logic [127:0] d0, input logic [1:0] st,
                        input logic v1, input logic [127:0] d1,
                        input logic [1:0] eu, input logic [1:0] er, input logic eb,
                        input img_t ex, input string tag);
      @(negedge clk);
      b0_valid = v0; b0_data = d0; b0_start = st;
      b1_valid = v1; b1_data = d1;
      #1;
      chk({tag, " used_cnt"},    128'(used_cnt),    128'(eu));
      chk({tag, " resume_slot"}, 128'(resume_slot), 128'(er));
      chk({tag, " bad_tmpl"},    128'(bad_tmpl),    128'(eb));
      sbq.push_back(ex);
      tagq.push_back(tag);
   endtask

   // monitor: compares registered port image after each edge
   initial begin
      forever begin
         @(posedge clk);
         #(PER/4);
         if (sbq.size() > 0) begin
            img_t e = sbq.pop_front();
            string t = tagq.pop_front();
            img_t g = got_img();
            checks++;
            if (g !== e) begin
               errors++;
               $display("FAIL %s ports got %h expected %h", t, g, e);
            end
         end
      end
   end

   initial begin
      #(PER*4000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      img_t e;
      #(PER*2 + 2);
      checks++;
      if (got_img() !== '0) begin
         errors++;
         $display("FAIL R10 ports during reset got %h expected 0", got_img());
      end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (got_img() !== '0) begin
         errors++;
         $display("FAIL R10 ports after reset got %h expected 0", got_img());
      end

      // R1 R3 R8: MII + MFB fully issued together
      e = '0;
      e.mv = 2'b11; e.mo[0] = sv(1,0); e.mo[1] = sv(2,0);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(1,1)}; e.io[1] = {41'd0, sv(1,2)};
      e.fv[0] = 1'b1; e.fo[0] = sv(2,1);
      e.bv[0] = 1'b1; e.bo[0] = sv(2,2);
      offer(1, mk(5'h00,1), 0, 1, mk(5'h16,2), 2, 0, 0, e, "R1_R8 MII+MFB");

      // R8: second MII lacks integer ports
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(3,0);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(3,1)}; e.io[1] = {41'd0, sv(3,2)};
      offer(1, mk(5'h00,3), 0, 1, mk(5'h00,4), 1, 0, 0, e, "R8 MII+MII");

      // R7: end stop blocks the second bundle
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(5,0);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(5,1)}; e.io[1] = {41'd0, sv(5,2)};
      offer(1, mk(5'h01,5), 0, 1, mk(5'h16,6), 1, 0, 0, e, "R7 end stop");

      // R7: stop after slot 0, then resume at slot 1 (R3)
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(7,0);
      offer(1, mk(5'h08,7), 0, 1, mk(5'h16,8), 0, 1, 0, e, "R7 stop after slot0");
      e = '0;
      e.mv = 2'b11; e.mo[0] = sv(7,1); e.mo[1] = sv(8,0);
      e.iv[0] = 1'b1; e.io[0] = {41'd0, sv(7,2)};
      e.fv[0] = 1'b1; e.fo[0] = sv(8,1);
      e.bv[0] = 1'b1; e.bo[0] = sv(8,2);
      offer(1, mk(5'h08,7), 1, 1, mk(5'h16,8), 2, 0, 0, e, "R3 resume at slot1");

      // R2: illegal first template
      e = '0;
      offer(1, mk(5'h1A,9), 0, 1, mk(5'h00,10), 1, 0, 1, e, "R2 illegal first");

      // R5: long pair on one integer port, second MII blocked
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(11,0);
      e.iv[0] = 1'b1; e.io[0] = {sv(11,2), sv(11,1)};
      offer(1, mk(5'h04,11), 0, 1, mk(5'h00,12), 1, 0, 0, e, "R5 MLX");

      // R4: second A falls back to the memory port
      e = '0;
      e.mv = 2'b11; e.mo[0] = sv(13,0); e.mo[1] = sv(14,1);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(13,2)}; e.io[1] = {41'd0, sv(14,0)};
      e.fv[0] = 1'b1; e.fo[0] = sv(13,1);
      e.bv[0] = 1'b1; e.bo[0] = sv(14,2);
      offer(1, mk(5'h0A,13), 0, 1, mk(5'h18,14), 2, 0, 0, e, "R4 MFI+AAB");

      // R9: nothing valid
      e = '0;
      offer(0, mk(5'h00,30), 2, 1, mk(5'h00,31), 0, 2, 0, e, "R9 idle");

      // R8: interior stop in second bundle
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(15,0);
      e.iv[0] = 1'b1; e.io[0] = {41'd0, sv(15,2)};
      e.fv[0] = 1'b1; e.fo[0] = sv(15,1);
      offer(1, mk(5'h0A,15), 0, 1, mk(5'h08,16), 1, 0, 0, e, "R8 interior stop");

      // R2: illegal second template is held back without the flag
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(17,0);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(17,1)}; e.io[1] = {41'd0, sv(17,2)};
      offer(1, mk(5'h00,17), 0, 1, mk(5'h1F,18), 1, 0, 0, e, "R2 illegal second");

      // R8: second bundle not valid
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(19,0);
      e.iv = 2'b11; e.io[0] = {41'd0, sv(19,1)}; e.io[1] = {41'd0, sv(19,2)};
      offer(1, mk(5'h00,19), 0, 0, mk(5'h16,20), 1, 0, 0, e, "R8 single bundle");

      // R7: stop after slot 1, then slot 2 with BBB (R3)
      e = '0;
      e.mv[0] = 1'b1; e.mo[0] = sv(20,0);
      e.iv[0] = 1'b1; e.io[0] = {41'd0, sv(20,1)};
      offer(1, mk(5'h02,20), 0, 1, mk(5'h12,21), 0, 2, 0, e, "R7 stop after slot1");
      e = '0;
      e.iv[0] = 1'b1; e.io[0] = {41'd0, sv(20,2)};
      e.bv = 3'b111; e.bo[0] = sv(21,0); e.bo[1] = sv(21,1); e.bo[2] = sv(21,2);
      offer(1, mk(5'h02,20), 2, 1, mk(5'h12,21), 2, 0, 0, e, "R3 resume at slot2");

      // R1: MIB + MBB spread over branch ports
      e = '0;
      e.mv = 2'b11; e.mo[0] = sv(22,0); e.mo[1] = sv(23,0);
      e.iv[0] = 1'b1; e.io[0] = {41'd0, sv(22,1)};
      e.bv = 3'b111; e.bo[0] = sv(22,2); e.bo[1] = sv(23,1); e.bo[2] = sv(23,2);
      offer(1, mk(5'h0E,22), 0, 1, mk(5'h10,23), 2, 0, 0, e, "R1 MIB+MBB");

      // R8: branch ports exhausted
      e = '0;
      e.bv = 3'b111; e.bo[0] = sv(24,0); e.bo[1] = sv(24,1); e.bo[2] = sv(24,2);
      offer(1, mk(5'h12,24), 0, 1, mk(5'h12,25), 1, 0, 0, e, "R8 BBB+BBB");

      // R8: memory ports exhausted
      e = '0;
      e.mv = 2'b11; e.mo[0] = sv(26,0); e.mo[1] = sv(26,1);
      e.fv[0] = 1'b1; e.fo[0] = sv(26,2);
      offer(1, mk(5'h0C,26), 0, 1, mk(5'h14,27), 1, 0, 0, e, "R8 MMF+MMB");

      // R9: drain with idle offers
      e = '0;
      offer(0, '0, 0, 0, '0, 0, 0, 0, e, "R9 drain");
      offer(0, '0, 1, 0, '0, 0, 1, 0, e, "R9 drain start1");
      @(negedge clk);
      b0_valid = 1'b0; b1_valid = 1'b0; b0_start = '0;
      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule